// File: doc/BRIEF.md
# Power-up reset delay timer

This block keeps a processor core in reset for a set number of ticks of a slow, free-running timing clock after a reset source lets go. The length of the hold depends on two things. One is whether this is the first delay since power-on or a later one. The other is the class of oscillator the core runs from: an RC oscillator, internal or external, or a crystal or resonator. Every delay that follows power-on is long, because the supply and the oscillator may both still be settling. A later delay is short in RC modes and stays long in crystal modes, because a crystal needs time to restart. In crystal modes a watchdog time-out starts a fresh delay.

The block runs entirely on the timing clock. Power-on reset arrives as an asynchronous, active-high input. The external reset pin arrives already synchronized to the timing clock, as an active-low level. While the pin is low, no counting takes place. Both delay lengths are parameters counted in timing-clock ticks, so a small configuration suits simulation.

Top module: `por_delay_timer`

## Requirements
- R1: While `por_i` is high, `core_rst` is 1 and `busy` is 0, regardless of every other input.
- R2: While `ext_rst_n` is sampled low, the next tick leaves `core_rst` at 1 and `busy` at 0. The count starts from zero at the first tick edge that samples `ext_rst_n` high.
- R3: The first delay after power-on lasts `LONG_TICKS` ticks in every oscillator mode. If the start edge is edge k, `core_rst` falls synchronously at edge k+`LONG_TICKS`, one tick after the terminal count. A completed delay ends the first-delay condition.
- R4: `osc_mode[2]` = 1 selects an RC mode, whatever the value of `osc_mode[1:0]`. In this mode, every delay after the first completed one lasts `SHORT_TICKS` ticks.
- R5: `osc_mode[2]` = 0 selects a crystal mode, whatever the value of `osc_mode[1:0]`. In this mode, every delay, including later ones, lasts `LONG_TICKS` ticks.
- R6: In a crystal mode, a tick that samples `wdt_timeout` high while `ext_rst_n` is high does three things. It sets `core_rst` to 1, starts counting from zero, and releases `core_rst` `LONG_TICKS` ticks later. This holds during a delay as well as after one.
- R7: In an RC mode, `wdt_timeout` has no effect. A released core stays released, and a running delay ends on its original schedule.
- R8: Driving `ext_rst_n` low during a delay aborts that delay. When the pin rises, the count restarts from zero. An aborted first delay still counts as the first delay.
- R9: `busy` is 1 exactly while a delay is counting, and `core_rst` is 1 whenever `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tmr_clk | input | 1 | Slow, independent timing clock; one edge is one tick |
| por_i | input | 1 | Power-on reset, asynchronous, active high |
| ext_rst_n | input | 1 | External reset pin level, synchronized, active low |
| wdt_timeout | input | 1 | Watchdog time-out pulse, sampled on the tick edge |
| osc_mode | input | 3 | Oscillator mode; bit 2 = 1 for RC, bit 2 = 0 for crystal |
| core_rst | output | 1 | Reset to the core, active high |
| busy | output | 1 | High while a delay is counting |

## Verification
On every tick, the assertions check four things: that the core is held whenever a count is running, that a low pin returns the block to the idle hold, that a crystal-mode watchdog pulse restarts the count while an RC-mode pulse leaves a released core untouched, and that the counter steps by one until the terminal count and then releases one tick later. Only the bench scenarios can show the full lengths of the delays. These include the long first delay, the short or long later delay for each of the eight mode codes, and the fact that an aborted first delay stays long. Each of these is measured as a tick count from the start edge to the release.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

   typedef enum logic [1:0] {
      ST_HOLD  = 2'd0,
      ST_COUNT = 2'd1,
      ST_DONE  = 2'd2
   } rdt_state_e;

   localparam int MODE_W = 3;

   // RC class when the top mode bit is set; lower bits do not matter here
   function automatic logic mode_is_rc(input logic [MODE_W-1:0] mode);
      return mode[MODE_W-1];
   endfunction

endpackage

// File: rtl/rdt_cause_flag.sv
module rdt_cause_flag (
   input  logic clk,
   input  logic por,
   input  logic first_done,
   output logic first_pending
);

   always_ff @(posedge clk or posedge por) begin
      if (por) begin
         first_pending <= 1'b1;
      end else if (first_done) begin
         first_pending <= 1'b0;
      end
   end

   p_flag_sticky_r3 : assert property (@(posedge clk) disable iff (por)
      !first_pending |=> !first_pending);

endmodule

// File: rtl/rdt_limit_sel.sv
module rdt_limit_sel #(
   parameter int LONG_TICKS  = 4608,
   parameter int SHORT_TICKS = 77,
   parameter int CNT_W       = $clog2(LONG_TICKS + 1)
) (
   input  logic             first_pending,
   input  logic             rc_mode,
   output logic [CNT_W-1:0] terminal
);

   localparam logic [CNT_W-1:0] LONG_TC  = CNT_W'(LONG_TICKS - 1);
   localparam logic [CNT_W-1:0] SHORT_TC = CNT_W'(SHORT_TICKS - 1);

   generate
      if (LONG_TICKS == SHORT_TICKS) begin : g_single
         logic unused_sel;
         assign unused_sel = first_pending ^ rc_mode;
         assign terminal   = LONG_TC;
      end else begin : g_dual
         always_comb begin
            if (rc_mode && !first_pending) terminal = SHORT_TC;
            else                           terminal = LONG_TC;
         end
      end
   endgenerate

   always_comb begin
      a_short_only_rc_r4 : assert (!(terminal != LONG_TC) || (rc_mode && !first_pending));
   end

endmodule

// File: rtl/rdt_seq.sv
module rdt_seq
   import rdt_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             por,
   input  logic             pin_hi,
   input  logic             retrig,
   input  logic [CNT_W-1:0] term_in,
   output logic             core_rst,
   output logic             busy,
   output logic             done
);

   rdt_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] term_q, term_d;
   logic             at_tc;

   assign at_tc = (cnt_q == term_q);
   assign done  = (state_q == ST_COUNT) && at_tc && pin_hi && !retrig;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      term_d  = term_q;
      if (!pin_hi) begin
         state_d = ST_HOLD;
         cnt_d   = '0;
      end else if (retrig || (state_q == ST_HOLD)) begin
         state_d = ST_COUNT;
         cnt_d   = '0;
         term_d  = term_in;
      end else if (state_q == ST_COUNT) begin
         if (at_tc) begin
            state_d = ST_DONE;
            cnt_d   = '0;
         end else begin
            cnt_d = cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or posedge por) begin
      if (por) begin
         state_q <= ST_HOLD;
         cnt_q   <= '0;
         term_q  <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         term_q  <= term_d;
      end
   end

   assign core_rst = (state_q != ST_DONE);
   assign busy     = (state_q == ST_COUNT);

   p_count_step_r3 : assert property (@(posedge clk) disable iff (por)
      (busy && pin_hi && !retrig && !at_tc) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));

   p_release_after_tc_r3 : assert property (@(posedge clk) disable iff (por)
      (busy && at_tc && pin_hi && !retrig) |=> !core_rst);

   p_restart_zero_r8 : assert property (@(posedge clk) disable iff (por)
      (!core_rst && pin_hi && retrig) |=> (busy && cnt_q == '0));

endmodule

// File: rtl/por_delay_timer.sv
module por_delay_timer
   import rdt_pkg::*;
#(
   parameter int LONG_TICKS  = 4608,
   parameter int SHORT_TICKS = 77
) (
   input  logic              tmr_clk,
   input  logic              por_i,
   input  logic              ext_rst_n,
   input  logic              wdt_timeout,
   input  logic [MODE_W-1:0] osc_mode,
   output logic              core_rst,
   output logic              busy
);

   localparam int CNT_W = $clog2(LONG_TICKS + 1);

   generate
      if (SHORT_TICKS < 1) begin : g_bad_short
         $error("SHORT_TICKS must be at least 1");
      end
      if (LONG_TICKS < 2) begin : g_bad_long
         $error("LONG_TICKS must be at least 2");
      end
      if (LONG_TICKS < SHORT_TICKS) begin : g_bad_order
         $error("LONG_TICKS must not be below SHORT_TICKS");
      end
   endgenerate

   logic             rc_mode;
   logic             retrig;
   logic             first_pending;
   logic             first_done;
   logic [CNT_W-1:0] terminal;

   assign rc_mode = mode_is_rc(osc_mode);
   assign retrig  = wdt_timeout && !rc_mode;

   rdt_cause_flag u_cause (
      .clk           (tmr_clk),
      .por           (por_i),
      .first_done    (first_done),
      .first_pending (first_pending)
   );

   rdt_limit_sel #(
      .LONG_TICKS  (LONG_TICKS),
      .SHORT_TICKS (SHORT_TICKS),
      .CNT_W       (CNT_W)
   ) u_limit (
      .first_pending (first_pending),
      .rc_mode       (rc_mode),
      .terminal      (terminal)
   );

   rdt_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk      (tmr_clk),
      .por      (por_i),
      .pin_hi   (ext_rst_n),
      .retrig   (retrig),
      .term_in  (terminal),
      .core_rst (core_rst),
      .busy     (busy),
      .done     (first_done)
   );

   p_busy_holds_core_r9 : assert property (@(posedge tmr_clk) disable iff (por_i)
      busy |-> core_rst);

   p_pin_low_hold_r2 : assert property (@(posedge tmr_clk) disable iff (por_i)
      !ext_rst_n |=> (core_rst && !busy));

   p_xtal_wdt_retrig_r6 : assert property (@(posedge tmr_clk) disable iff (por_i)
      (ext_rst_n && wdt_timeout && !osc_mode[MODE_W-1]) |=> (core_rst && busy));

   p_rc_wdt_ignored_r7 : assert property (@(posedge tmr_clk) disable iff (por_i)
      (!core_rst && ext_rst_n && wdt_timeout && osc_mode[MODE_W-1]) |=> !core_rst);

   p_release_ends_first_r3 : assert property (@(posedge tmr_clk) disable iff (por_i)
      $fell(core_rst) |-> !first_pending);

endmodule

// File: tb/por_delay_timer_tb.sv
module por_delay_timer_tb;

   localparam int LONG  = 40;
   localparam int SHORT = 6;

   logic       clk = 1'b0;
   logic       por = 1'b1;
   logic       pin = 1'b1;
   logic       wdt = 1'b0;
   logic [2:0] mode = 3'd0;
   logic       core_rst;
   logic       busy;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #2.5 clk = ~clk;

   por_delay_timer #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) u_dut (
      .tmr_clk     (clk),
      .por_i       (por),
      .ext_rst_n   (pin),
      .wdt_timeout (wdt),
      .osc_mode    (mode),
      .core_rst    (core_rst),
      .busy        (busy)
   );

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, act=%0d exp<=150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s mode=%0d act=%0d exp=%0d", req, mode, act, exp);
      end
   endtask

   // one tick: posedge, then settle at the falling edge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // counts start-edge-inclusive ticks until core_rst falls; wdt drops after tick 1
   task automatic count_from(input int n0, output int n);
      bit busy_bad = 0;
      n = n0;
      do begin
         tick();
         n++;
         wdt = 1'b0;
         if (core_rst && !busy) busy_bad = 1;
      end while (core_rst && n < 500);
      chk(!busy_bad, "R9 busy during delay", busy_bad, 0);
      chk(!busy, "R9 busy after release", busy, 0);
   endtask

   task automatic do_por(input logic [2:0] m, input logic pin_lvl);
      mode = m; pin = pin_lvl; wdt = 1'b0; por = 1'b1;
      repeat (3) tick();
      chk(core_rst && !busy, "R1 por hold", {core_rst, busy}, 2);
      por = 1'b0;
   endtask

   int n;
   int later;
   bit rc;

   initial begin
      @(negedge clk);
      chk(core_rst && !busy, "R1 reset state", {core_rst, busy}, 2);

      for (int m = 0; m < 8; m++) begin
         rc    = m[2];
         later = rc ? SHORT : LONG;

         // first delay after power-on
         do_por(3'(m), 1'b1);
         count_from(0, n);
         chk(n == LONG + 1, "R3 first delay", n, LONG + 1);

         // external reset: hold then later delay
         pin = 1'b0;
         tick(); tick();
         chk(core_rst && !busy, "R2 pin low holds", {core_rst, busy}, 2);
         pin = 1'b1;
         count_from(0, n);
         chk(n == later + 1, rc ? "R4 later delay rc" : "R5 later delay xtal", n, later + 1);

         // watchdog after release
         wdt = 1'b1;
         if (rc) begin
            tick(); wdt = 1'b0;
            repeat (5) tick();
            chk(!core_rst && !busy, "R7 rc wdt ignored", {core_rst, busy}, 0);
         end else begin
            count_from(0, n);
            chk(n == LONG + 1, "R6 xtal wdt retrigger", n, LONG + 1);
         end

         // abort a later delay
         pin = 1'b0; tick(); pin = 1'b1;
         tick(); tick();
         chk(busy, "R9 busy while counting", busy, 1);
         pin = 1'b0; tick();
         chk(core_rst && !busy, "R8 abort holds", {core_rst, busy}, 2);
         pin = 1'b1;
         count_from(0, n);
         chk(n == later + 1, "R8 restart after abort", n, later + 1);

         // watchdog in the middle of a later delay
         pin = 1'b0; tick(); pin = 1'b1;
         n = 0;
         repeat (3) begin tick(); n++; end
         wdt = 1'b1;
         if (rc) begin
            count_from(n, n);
            chk(n == SHORT + 1, "R7 rc wdt mid-delay", n, SHORT + 1);
         end else begin
            count_from(0, n);
            chk(n == LONG + 1, "R6 xtal wdt mid-delay", n, LONG + 1);
         end
      end

      // power-on with pin low, then abort the first delay: still long
      for (int m = 4; m < 8; m += 3) begin
         do_por(3'(m), 1'b0);
         repeat (4) tick();
         chk(core_rst && !busy, "R2 pin low after por", {core_rst, busy}, 2);
         pin = 1'b1;
         repeat (5) tick();
         pin = 1'b0; tick();
         pin = 1'b1;
         count_from(0, n);
         chk(n == LONG + 1, "R8 aborted first stays long", n, LONG + 1);
         pin = 1'b0; tick(); pin = 1'b1;
         count_from(0, n);
         chk(n == SHORT + 1, "R3 first flag cleared", n, SHORT + 1);
      end

      // por asserted mid-delay forces reset state
      pin = 1'b0; tick(); pin = 1'b1; tick(); tick();
      por = 1'b1; #1;
      chk(core_rst && !busy, "R1 async por", {core_rst, busy}, 2);
      @(negedge clk);
      por = 1'b0;

      summary();
      $finish;
   end

endmodule